// File: doc/BRIEF.md
# Tagged-FIFO I2C Bus Master

This block is a register-mapped I2C bus master. Software builds a whole bus transaction by pushing 10-bit words into a transmit queue. The low byte of each word is the byte to send. Two tag bits beside the byte ask for a START (or repeated START) before the byte and a STOP after its acknowledge slot. The byte carried by a START-tagged word is the address byte. Its bit 0 selects the direction, and 1 means read.

Once a read address has gone out, each further queued word is only a trigger. It clocks one byte in from the device, and that byte lands in a receive queue. A STOP tag on a trigger makes the master NACK that last byte and then close the bus. A lone START+STOP word acts as a presence probe. The outcome shows in the status word. The SCL high and low times are set separately, in system clock cycles. A self-clearing soft reset flushes both queues, releases the bus and clears the status.

The bus pins are open-drain. A high `scl_oe` or `sda_oe` pulls that line low, and `sda_i` is the resolved SDA level.

Top module: `i2c_tagged_master`

## Requirements
- R1: Eight register slots are selected by `reg_idx`: 0 is the data port (a write pushes the TX queue, a read pops the RX queue), 1 is status, 2 is control, 3 is the SCL high time, 4 is the SCL low time, 5 is the own address, 6 is the RX level and 7 is the TX level. After reset the status reads 0x200, both periods read 8, and the levels and control read 0.
- R2: A TX word holds the byte in bits 7:0, START in bit 8 and STOP in bit 9. A word without START that reaches an idle master is dropped without any bus activity.
- R3: Written bytes go out MSB first, with SDA changing only while SCL is low. The master releases SDA in the ninth clock so the device can acknowledge.
- R4: After an address byte with bit 0 set, every later word clocks in one byte. The master ACKs each of these bytes except one whose word carries STOP; that byte gets a NACK and is followed by a STOP.
- R5: Status bit 0 sets when a STOP completes, and status bit 2 sets when an address or data byte is not acknowledged. Writing 1 to either bit clears it.
- R6: Status bit 9 is set while the RX queue is empty, and status bit 10 is set while the TX queue is full. A push to a full TX queue is ignored. A read of an empty RX queue returns 0 and changes nothing.
- R7: Each queue holds 4 entries, and slots 6 and 7 report how many entries are held.
- R8: Inside a transfer, SCL stays high for the slot-3 value and low for the slot-4 value, both counted in clock cycles (10-bit registers; 0 acts as 1).
- R9: A START-tagged word in mid-transaction produces a repeated START and a new address byte.
- R10: When the TX queue runs dry in mid-transaction, the master holds SCL low until another word arrives, and status bit 3 is set while it waits.
- R11: Writing control bit 8 starts a soft reset. The bit reads 1 in the cycle after the write and 0 in the cycle after that. It empties both queues, releases both lines and clears status bits 0 and 2.
- R12: A single START+STOP address word probes a device. Done sets, and bit 2 tells whether the address went unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on slot 0) |
| reg_idx | input | 3 | Register slot index |
| reg_wdata | input | 10 | Write data (low bits of the 32-bit slot) |
| reg_rdata | output | 32 | Read data, combinational from `reg_idx` |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` 1 ns after it sets the strobe, while the strobe is still asserted. A write takes effect at the next rising edge, so levels, the full flag and the soft-reset bit are read in the cycle right after the write cycle. The soft-reset bit is read once in that cycle, expecting 1, and once in the next, expecting 0. Bus results come after a whole transaction, so the bench polls status bit 0 and only then checks the bytes logged by its device model, the RX contents and the ACK/NACK pattern. SCL high and low widths are measured edge to edge in clock cycles on the resolved lines.

// File: rtl/i2c_tm_pkg.sv
package i2c_tm_pkg;

    localparam int PER_W     = 10;
    localparam int BYTE_W    = 8;
    localparam int WDATA_W   = 10;
    localparam int RDATA_W   = 32;
    localparam int IDX_W     = 3;

    localparam int SB_DONE   = 0;
    localparam int SB_NACK   = 2;
    localparam int SB_WAIT   = 3;
    localparam int SB_RXE    = 9;
    localparam int SB_TXF    = 10;
    localparam int CB_SRST   = 8;

    typedef enum logic [IDX_W-1:0] {
        RG_DATA = 3'd0,
        RG_STAT = 3'd1,
        RG_CTRL = 3'd2,
        RG_SCLH = 3'd3,
        RG_SCLL = 3'd4,
        RG_OWN  = 3'd5,
        RG_RXLV = 3'd6,
        RG_TXLV = 3'd7
    } reg_slot_e;

    typedef struct packed {
        logic              stop;
        logic              start;
        logic [BYTE_W-1:0] data;
    } tx_word_t;

    typedef enum logic [3:0] {
        E_IDLE, E_START, E_BIT_LO, E_BIT_HI, E_HOLD,
        E_RS_LO, E_RS_HI, E_STOP_LO, E_STOP_HI, E_STOP_REL
    } eng_st_e;

    function automatic logic [PER_W-1:0] eff_per(input logic [PER_W-1:0] p);
        return (p == '0) ? PER_W'(1) : p;
    endfunction

endpackage

// File: rtl/i2c_tm_fifo.sv
module i2c_tm_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rptr <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= nxt(wptr);
            if (do_pop)  rptr <= nxt(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/i2c_tm_engine.sv
module i2c_tm_engine
    import i2c_tm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              tx_valid,
    input  tx_word_t          tx_word,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    input  logic [PER_W-1:0]  hi_per,
    input  logic [PER_W-1:0]  lo_per,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              done_pulse,
    output logic              nack_pulse,
    output logic              waiting
);
    eng_st_e           st;
    logic [PER_W-1:0]  tmr, per;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic              stop_f, rd_mode, is_addr;
    logic              hi_state, timed, tdone, receiving, bit_drv, ack_end;

    assign hi_state  = st inside {E_START, E_BIT_HI, E_RS_HI, E_STOP_HI, E_STOP_REL};
    assign timed     = !(st inside {E_IDLE, E_HOLD});
    assign per       = hi_state ? eff_per(hi_per) : eff_per(lo_per);
    assign tdone     = (tmr >= per - 1'b1);
    assign receiving = rd_mode && !is_addr;
    assign bit_drv   = (bitn != 4'd8) ? (!receiving && !shreg[BYTE_W-1])
                                      : (receiving && !stop_f);
    assign ack_end   = (st == E_BIT_HI) && tdone && (bitn == 4'd8);

    assign tx_pop     = (st == E_IDLE || st == E_HOLD) && tx_valid;
    assign waiting    = (st == E_HOLD) && !tx_valid;
    assign rx_push    = ack_end && receiving;
    assign rx_byte    = shreg;
    assign nack_pulse = ack_end && !receiving && sda_i;
    assign done_pulse = (st == E_STOP_REL) && tdone;
    assign scl_oe     = st inside {E_BIT_LO, E_HOLD, E_RS_LO, E_STOP_LO};

    always_comb begin
        case (st)
            E_START, E_STOP_LO, E_STOP_HI: sda_oe = 1'b1;
            E_BIT_LO, E_BIT_HI:            sda_oe = bit_drv;
            default:                       sda_oe = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st      <= E_IDLE;
            tmr     <= '0;
            bitn    <= '0;
            shreg   <= '0;
            stop_f  <= 1'b0;
            rd_mode <= 1'b0;
            is_addr <= 1'b0;
        end else begin
            tmr <= (timed && !tdone) ? tmr + 1'b1 : '0;
            case (st)
                E_IDLE: if (tx_valid && tx_word.start) begin
                    shreg   <= tx_word.data;
                    stop_f  <= tx_word.stop;
                    rd_mode <= tx_word.data[0];
                    is_addr <= 1'b1;
                    bitn    <= '0;
                    st      <= E_START;
                end
                E_START:  if (tdone) st <= E_BIT_LO;
                E_BIT_LO: if (tdone) st <= E_BIT_HI;
                E_BIT_HI: if (tdone) begin
                    if (bitn != 4'd8) begin
                        shreg <= {shreg[BYTE_W-2:0], sda_i};
                        bitn  <= bitn + 1'b1;
                        st    <= E_BIT_LO;
                    end else begin
                        is_addr <= 1'b0;
                        st      <= stop_f ? E_STOP_LO : E_HOLD;
                    end
                end
                E_HOLD: if (tx_valid) begin
                    shreg  <= tx_word.data;
                    stop_f <= tx_word.stop;
                    bitn   <= '0;
                    if (tx_word.start) begin
                        rd_mode <= tx_word.data[0];
                        is_addr <= 1'b1;
                        st      <= E_RS_LO;
                    end else begin
                        st <= E_BIT_LO;
                    end
                end
                E_RS_LO:    if (tdone) st <= E_RS_HI;
                E_RS_HI:    if (tdone) st <= E_START;
                E_STOP_LO:  if (tdone) st <= E_STOP_HI;
                E_STOP_HI:  if (tdone) st <= E_STOP_REL;
                E_STOP_REL: if (tdone) st <= E_IDLE;
                default:    st <= E_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_tagged_master.sv
module i2c_tagged_master
    import i2c_tm_pkg::*;
#(
    parameter int               FIFO_DEPTH = 4,
    parameter logic [PER_W-1:0] DEF_HI     = 10'd8,
    parameter logic [PER_W-1:0] DEF_LO     = 10'd8,
    localparam int              LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [RDATA_W-1:0] reg_rdata,
    input  logic               sda_i,
    output logic               scl_oe,
    output logic               sda_oe
);
    reg_slot_e         slot;
    logic              srst_q, done_q, nack_q;
    logic [PER_W-1:0]  hi_q, lo_q;
    logic [6:0]        own_q;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    tx_word_t          tx_head;
    logic [BYTE_W-1:0] rx_in, rx_head;
    logic              eng_wait, eng_done, eng_nack;
    logic              wr_stat;

    assign slot    = reg_slot_e'(reg_idx);
    assign tx_push = reg_wr && (slot == RG_DATA) && !srst_q;
    assign rx_pop  = reg_rd && (slot == RG_DATA);
    assign wr_stat = reg_wr && (slot == RG_STAT);

    i2c_tm_fifo #(.W(WDATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(srst_q),
        .push(tx_push), .din(reg_wdata), .pop(tx_pop), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .level(tx_lvl)
    );

    i2c_tm_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(srst_q),
        .push(rx_push), .din(rx_in), .pop(rx_pop), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .level(rx_lvl)
    );

    i2c_tm_engine u_eng (
        .clk(clk), .rst(rst), .flush(srst_q),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_in),
        .hi_per(hi_q), .lo_per(lo_q), .sda_i(sda_i),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .done_pulse(eng_done), .nack_pulse(eng_nack), .waiting(eng_wait)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q <= 1'b0;
            done_q <= 1'b0;
            nack_q <= 1'b0;
            hi_q   <= DEF_HI;
            lo_q   <= DEF_LO;
            own_q  <= '0;
        end else begin
            srst_q <= reg_wr && (slot == RG_CTRL) && reg_wdata[CB_SRST];
            if (srst_q) begin
                done_q <= 1'b0;
                nack_q <= 1'b0;
            end else begin
                if (eng_done)                         done_q <= 1'b1;
                else if (wr_stat && reg_wdata[SB_DONE]) done_q <= 1'b0;
                if (eng_nack)                         nack_q <= 1'b1;
                else if (wr_stat && reg_wdata[SB_NACK]) nack_q <= 1'b0;
            end
            if (reg_wr && slot == RG_SCLH) hi_q  <= reg_wdata[PER_W-1:0];
            if (reg_wr && slot == RG_SCLL) lo_q  <= reg_wdata[PER_W-1:0];
            if (reg_wr && slot == RG_OWN)  own_q <= reg_wdata[6:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (slot)
            RG_DATA: reg_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
            RG_STAT: begin
                reg_rdata[SB_DONE] = done_q;
                reg_rdata[SB_NACK] = nack_q;
                reg_rdata[SB_WAIT] = eng_wait;
                reg_rdata[SB_RXE]  = rx_empty;
                reg_rdata[SB_TXF]  = tx_full;
            end
            RG_CTRL: reg_rdata[CB_SRST]     = srst_q;
            RG_SCLH: reg_rdata[PER_W-1:0]   = hi_q;
            RG_SCLL: reg_rdata[PER_W-1:0]   = lo_q;
            RG_OWN:  reg_rdata[6:0]         = own_q;
            RG_RXLV: reg_rdata[LVL_W-1:0]   = rx_lvl;
            RG_TXLV: reg_rdata[LVL_W-1:0]   = tx_lvl;
            default: reg_rdata = '0;
        endcase
    end

    logic unused_rx_full;
    assign unused_rx_full = rx_full;
endmodule

// File: rtl/i2c_tm_checker.sv
module i2c_tm_checker #(
    parameter int  DEPTH = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [2:0]    reg_idx,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          srst_q,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input logic          tx_pop,
    input logic          eng_wait,
    input logic          eng_done
);
    AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        tx_lvl <= LW'(DEPTH)); // R7
    AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_lvl <= LW'(DEPTH)); // R7
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl == LW'(DEPTH) && reg_wr && reg_idx == 3'd0 && !tx_pop && !srst_q)
        |=> (tx_lvl == LW'(DEPTH))); // R6
    AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (srst_q && !reg_wr) |=> !srst_q); // R11
    AST_SRST_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (tx_lvl == '0 && rx_lvl == '0 && !scl_oe && !sda_oe)); // R11
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst)
        eng_wait |-> scl_oe); // R10
    AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (!scl_oe && !sda_oe)); // R5
endmodule

bind i2c_tagged_master i2c_tm_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .srst_q(srst_q),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_pop(tx_pop),
    .eng_wait(eng_wait), .eng_done(eng_done)
);

// File: tb/i2c_tagged_master_tb.sv
module i2c_tagged_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [9:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe, sda_oe;
    logic        s_pull = 1'b0;
    wire         scl_line = !scl_oe;
    wire         sda_line = !(sda_oe || s_pull);

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    i2c_tagged_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- device model at address 0x50 ----------------
    localparam logic [6:0] DEV = 7'h50;
    logic ps = 1'b1, pd = 1'b1;
    bit   active, skipf, isaddr, matched, rdir, tx, mack;
    int   cnt, wn, ack_cnt, nack_cnt, start_cnt;
    logic [7:0] sh, txb, rdbyte;
    logic [7:0] wlog [16];

    task automatic dev_idle();
        active = 0; s_pull = 0; tx = 0; cnt = 0;
    endtask

    always @(negedge clk) begin
        if (ps && scl_line && pd && !sda_line) begin
            active = 1; skipf = 1; cnt = 0; isaddr = 1; s_pull = 0; tx = 0;
            start_cnt++;
        end else if (ps && scl_line && !pd && sda_line) begin
            active = 0; s_pull = 0; tx = 0;
        end else if (active && !ps && scl_line) begin
            if (cnt < 8) sh = {sh[6:0], sda_line};
            else if (tx) begin
                mack = !sda_line;
                if (mack) ack_cnt++; else nack_cnt++;
            end
        end else if (active && ps && !scl_line) begin
            if (skipf) skipf = 0;
            else if (cnt < 7) begin
                cnt++;
                if (tx) begin txb = txb << 1; s_pull = !txb[7]; end
            end else if (cnt == 7) begin
                cnt = 8;
                if (tx) s_pull = 0;
                else if (isaddr) begin
                    matched = (sh[7:1] == DEV); rdir = sh[0]; s_pull = matched;
                end else begin
                    if (matched && wn < 16) begin wlog[wn] = sh; wn++; end
                    s_pull = matched;
                end
            end else begin
                cnt = 0;
                if (isaddr) begin
                    isaddr = 0;
                    if (matched && rdir) begin
                        tx = 1; txb = rdbyte; rdbyte++; s_pull = !txb[7];
                    end else s_pull = 0;
                end else if (tx) begin
                    if (mack) begin txb = rdbyte; rdbyte++; s_pull = !txb[7]; end
                    else begin tx = 0; s_pull = 0; end
                end else s_pull = 0;
            end
        end
        ps = scl_line; pd = sda_line;
    end

    // ---------------- SCL width / activity monitor ----------------
    logic mps = 1'b1;
    int   t_rise, t_fall, hmin, hmax, lmin, lmax, falls;
    bit   have_r, have_f;
    task automatic mon_clear();
        hmin = 9999; hmax = 0; lmin = 9999; lmax = 0; have_r = 0; have_f = 0;
    endtask
    always @(negedge clk) begin
        cyc++;
        if (mps && !scl_line) begin
            falls++;
            if (have_r) begin
                if (cyc - t_rise < hmin) hmin = cyc - t_rise;
                if (cyc - t_rise > hmax) hmax = cyc - t_rise;
            end
            t_fall = cyc; have_f = 1;
        end else if (!mps && scl_line) begin
            if (have_f) begin
                if (cyc - t_fall < lmin) lmin = cyc - t_fall;
                if (cyc - t_fall > lmax) lmax = cyc - t_fall;
            end
            t_rise = cyc; have_r = 1;
        end
        mps = scl_line;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [9:0] d);
        reg_wr = 1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] d);
        reg_rd = 1; reg_idx = i;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = '0;
        for (int k = 0; k < 5000 && !s[0]; k++) rd(3'd1, s);
        chk(req, {31'b0, s[0]}, 32'd1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] v;
        rd(3'd1, v); chk("R1 status after reset", v, 32'h200);
        rd(3'd3, v); chk("R1 sclh default", v, 32'd8);
        rd(3'd4, v); chk("R1 scll default", v, 32'd8);
        rd(3'd6, v); chk("R1 rx level", v, 32'd0);
        rd(3'd7, v); chk("R1 tx level", v, 32'd0);
        rd(3'd2, v); chk("R1 control", v, 32'd0);
        chk("R1 bus released", {30'b0, scl_oe, sda_oe}, 32'd0);
    endtask

    task automatic t_timing_probe();
        logic [31:0] v;
        wr(3'd3, 10'd3); wr(3'd4, 10'd5);
        rd(3'd3, v); chk("R8 sclh readback", v, 32'd3);
        rd(3'd4, v); chk("R8 scll readback", v, 32'd5);
        mon_clear();
        wr(3'd0, 10'h3A0);
        wait_done("R12 probe present done");
        rd(3'd1, v); chk("R12 probe present no nack", v, 32'h201);
        chk("R8 high min", hmin, 32'd3); chk("R8 high max", hmax, 32'd3);
        chk("R8 low min", lmin, 32'd5);  chk("R8 low max", lmax, 32'd5);
        wr(3'd1, 10'h1);
        rd(3'd1, v); chk("R5 done cleared by W1C", v, 32'h200);
    endtask

    task automatic t_probe_absent();
        logic [31:0] v;
        wr(3'd0, 10'h344);
        wait_done("R12 probe absent done");
        rd(3'd1, v); chk("R12 R5 probe absent nack", v, 32'h205);
        wr(3'd1, 10'h5);
        rd(3'd1, v); chk("R5 nack cleared by W1C", v, 32'h200);
    endtask

    task automatic t_write_fill();
        logic [31:0] v;
        wn = 0;
        wr(3'd0, 10'h1A0); wr(3'd0, 10'h011); wr(3'd0, 10'h022);
        wr(3'd0, 10'h033); wr(3'd0, 10'h244); wr(3'd0, 10'h255);
        rd(3'd7, v); chk("R7 tx level full", v, 32'd4);
        rd(3'd1, v); chk("R6 tx full flag", v & 32'h400, 32'h400);
        wait_done("R3 write done");
        chk("R6 dropped word not sent", wn, 32'd4);
        chk("R3 byte0", wlog[0], 32'h11); chk("R3 byte1", wlog[1], 32'h22);
        chk("R3 byte2", wlog[2], 32'h33); chk("R3 byte3", wlog[3], 32'h44);
        rd(3'd1, v); chk("R5 write acked", v, 32'h201);
        wr(3'd1, 10'h1);
    endtask

    task automatic t_read();
        logic [31:0] v;
        rdbyte = 8'hC3; ack_cnt = 0; nack_cnt = 0;
        wr(3'd0, 10'h1A1); wr(3'd0, 10'h000); wr(3'd0, 10'h000); wr(3'd0, 10'h200);
        wait_done("R4 read done");
        rd(3'd6, v); chk("R7 rx level", v, 32'd3);
        rd(3'd0, v); chk("R4 rx byte0", v, 32'hC3);
        rd(3'd0, v); chk("R4 rx byte1", v, 32'hC4);
        rd(3'd0, v); chk("R4 rx byte2", v, 32'hC5);
        chk("R4 master acks", ack_cnt, 32'd2);
        chk("R4 master nack on last", nack_cnt, 32'd1);
        rd(3'd0, v); chk("R6 empty read returns 0", v, 32'd0);
        rd(3'd6, v); chk("R6 empty read keeps level", v, 32'd0);
        rd(3'd1, v); chk("R6 rx empty flag", v, 32'h201);
        wr(3'd1, 10'h1);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wn = 0; rdbyte = 8'h60; start_cnt = 0;
        wr(3'd0, 10'h1A0); wr(3'd0, 10'h007); wr(3'd0, 10'h1A1); wr(3'd0, 10'h200);
        wait_done("R9 combined done");
        chk("R9 two starts", start_cnt, 32'd2);
        chk("R9 pointer written", {wn[23:0], wlog[0]}, {24'd1, 8'h07});
        rd(3'd0, v); chk("R9 byte read after restart", v, 32'h60);
        wr(3'd1, 10'h1);
    endtask

    task automatic t_wait();
        logic [31:0] v;
        int rel;
        wn = 0; v = '0;
        wr(3'd0, 10'h1A0);
        for (int k = 0; k < 2000 && !v[3]; k++) rd(3'd1, v);
        chk("R10 wait flag", v & 32'h8, 32'h8);
        rel = 0;
        for (int k = 0; k < 50; k++) begin @(negedge clk); if (!scl_oe) rel++; end
        chk("R10 scl held low", rel, 32'd0);
        wr(3'd0, 10'h299);
        wait_done("R10 resume done");
        chk("R10 byte after resume", wlog[0], 32'h99);
        rd(3'd1, v); chk("R10 wait flag gone", v, 32'h201);
        wr(3'd1, 10'h1);
    endtask

    task automatic t_discard();
        logic [31:0] v;
        int f0;
        f0 = falls;
        wr(3'd0, 10'h055);
        idle(100);
        rd(3'd7, v); chk("R2 untagged word dropped", v, 32'd0);
        chk("R2 no bus activity", falls - f0, 32'd0);
        rd(3'd1, v); chk("R2 no done", v, 32'h200);
    endtask

    task automatic t_srst();
        logic [31:0] v;
        wr(3'd0, 10'h1A0); wr(3'd0, 10'h011); wr(3'd0, 10'h022);
        wr(3'd2, 10'h100);
        rd(3'd2, v); chk("R11 srst reads 1", v, 32'h100);
        rd(3'd2, v); chk("R11 srst self clears", v, 32'h0);
        dev_idle();
        rd(3'd7, v); chk("R11 tx flushed", v, 32'd0);
        rd(3'd1, v); chk("R11 status cleared", v, 32'h200);
        chk("R11 bus released", {30'b0, scl_oe, sda_oe}, 32'd0);
        idle(5);
        wr(3'd0, 10'h3A0);
        wait_done("R11 usable after srst");
        rd(3'd1, v); chk("R11 probe after srst", v, 32'h201);
    endtask

    initial begin
        mon_clear();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_timing_probe();
        t_probe_absent();
        t_write_fill();
        t_read();
        t_restart();
        t_wait();
        t_discard();
        t_srst();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (!finished && cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule